// File: doc/BRIEF.md
# GPIO Port Register Bank with Error Response

This block controls 32 general-purpose I/O pins through a small memory-mapped register window. The bus master writes an output value word, or changes chosen bits of it through separate set and clear words. A direction word decides, pin by pin, whether the stored output value drives the pin. Pin levels pass through a two-flop synchronizer and can be read back as an input word.

The bus is a plain request/ready handshake with an error flag. The master raises `bus_req` with the offset, the direction of the access and the write data, and holds them until `bus_ready` is high at a clock edge. Accesses to a mapped word finish in the same cycle. An access to any other offset gets one wait state and then finishes with `bus_err` set. An access that errors changes no register.

Top module: `gpio_port_bank`

## Requirements
- R1: After reset the output value word and the direction word are all zeros, so `pin_out` and `pin_oe` are both 0.
- R2: The output value word at offset 0x00 is readable and writable. Any access to a mapped offset has `bus_ready` high and `bus_err` low in the cycle the request is presented (zero wait states).
- R3: Writing to offset 0x04 sets every output value bit whose write-data bit is 1 and leaves the other bits unchanged. A read of 0x04 returns 0.
- R4: Writing to offset 0x08 clears every output value bit whose write-data bit is 1 and leaves the other bits unchanged. A read of 0x08 returns 0.
- R5: The direction word at offset 0x14 is readable and writable. A 1 in bit n makes pin n an output, and a 0 makes it an input. `pin_oe[n]` equals direction bit n.
- R6: `pin_out[n]` equals bit n of the output value word, whatever the direction bit.
- R7: A read of offset 0x10 returns `pin_in` after a two-flop synchronizer. A change on the pins is first visible in a read made after two rising clock edges. A write to 0x10 finishes with no error and no wait state, and it changes nothing.
- R8: An access to any offset other than 0x00, 0x04, 0x08, 0x10 and 0x14 (unaligned offsets and 0x0C included) has `bus_ready` and `bus_err` both low in its first cycle. In the next cycle both are high. `bus_err` is never high without `bus_ready`.
- R9: An access that ends with an error leaves the output value word and the direction word unchanged.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rst | input | 1 | Synchronous reset, active high |
| bus_req | input | 1 | Access request, held until ready |
| bus_we | input | 1 | 1 for a write, 0 for a read |
| bus_addr | input | 8 | Byte offset inside the register window |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data, valid while ready is high on a read |
| bus_ready | output | 1 | Access finishes at this clock edge |
| bus_err | output | 1 | The finishing access was to an unmapped offset |
| pin_in | input | 32 | Asynchronous pin levels |
| pin_out | output | 32 | Value driven on each pin |
| pin_oe | output | 32 | Per-pin output enable |

## Verification
The assertions assume that the master follows the handshake. Once `bus_req` is raised, the offset, direction and write data stay unchanged until an edge where `bus_ready` is high, and `bus_req` does not rise again within that edge. The bench's single access task enforces this: it drives a request at a falling edge, holds it through any wait state, and drops it just after the finishing edge. The pins are changed only between accesses, and they are left stable for at least two edges before the input word is compared, so each expected read value is well defined.

// File: rtl/gpio_pkg.sv
package gpio_pkg;

    localparam logic [31:0] OFF_DOUT = 32'h00;
    localparam logic [31:0] OFF_SET  = 32'h04;
    localparam logic [31:0] OFF_CLR  = 32'h08;
    localparam logic [31:0] OFF_DIN  = 32'h10;
    localparam logic [31:0] OFF_DIR  = 32'h14;

    typedef enum logic [2:0] {
        SEL_DOUT,
        SEL_SET,
        SEL_CLR,
        SEL_DIN,
        SEL_DIR,
        SEL_NONE
    } reg_sel_e;

    typedef struct packed {
        logic     fire;   // access executes this cycle
        logic     wr;
        reg_sel_e sel;
    } acc_t;

    function automatic reg_sel_e decode_offset(input logic [31:0] off);
        reg_sel_e s;
        case (off)
            OFF_DOUT: s = SEL_DOUT;
            OFF_SET:  s = SEL_SET;
            OFF_CLR:  s = SEL_CLR;
            OFF_DIN:  s = SEL_DIN;
            OFF_DIR:  s = SEL_DIR;
            default:  s = SEL_NONE;
        endcase
        return s;
    endfunction

endpackage

// File: rtl/gpio_addr_dec.sv
module gpio_addr_dec
    import gpio_pkg::*;
#(
    parameter int OFFS_W = 8
) (
    input  logic              req,
    input  logic              we,
    input  logic [OFFS_W-1:0] addr,
    input  logic              err_pend,
    output logic              mapped,
    output acc_t              acc
);
    localparam int PAD_W = 32 - OFFS_W;

    reg_sel_e sel;

    always_comb begin
        sel      = decode_offset({{PAD_W{1'b0}}, addr});
        mapped   = (sel != SEL_NONE);
        acc.fire = req && mapped && !err_pend;
        acc.wr   = we;
        acc.sel  = sel;
    end
endmodule

// File: rtl/gpio_err_fsm.sv
module gpio_err_fsm (
    input  logic clk,
    input  logic rst,
    input  logic req,
    input  logic mapped,
    output logic err_pend,
    output logic ready,
    output logic err
);
    typedef enum logic {ST_IDLE, ST_ERR} st_e;

    st_e st_q, st_d;

    always_comb begin
        st_d = st_q;
        case (st_q)
            ST_IDLE: if (req && !mapped) st_d = ST_ERR;
            ST_ERR:  st_d = ST_IDLE;
            default: st_d = ST_IDLE;
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst) st_q <= ST_IDLE;
        else     st_q <= st_d;
    end

    always_comb begin
        err_pend = (st_q == ST_ERR);
        err      = err_pend;
        ready    = err_pend || (req && mapped);
    end
endmodule

// File: rtl/gpio_out_regs.sv
module gpio_out_regs
    import gpio_pkg::*;
#(
    parameter int PIN_W = 32
) (
    input  logic             clk,
    input  logic             rst,
    input  acc_t             acc,
    input  logic [PIN_W-1:0] wdata,
    output logic [PIN_W-1:0] dout,
    output logic [PIN_W-1:0] dir
);
    logic wr_en;

    assign wr_en = acc.fire && acc.wr;

    always_ff @(posedge clk) begin
        if (rst) begin
            dout <= '0;
            dir  <= '0;
        end else if (wr_en) begin
            case (acc.sel)
                SEL_DOUT: dout <= wdata;
                SEL_SET:  dout <= dout | wdata;
                SEL_CLR:  dout <= dout & ~wdata;
                SEL_DIR:  dir  <= wdata;
                default:  ;
            endcase
        end
    end
endmodule

// File: rtl/gpio_in_sync.sv
module gpio_in_sync #(
    parameter int PIN_W  = 32,
    parameter int STAGES = 2
) (
    input  logic             clk,
    input  logic             rst,
    input  logic [PIN_W-1:0] pins,
    output logic [PIN_W-1:0] synced
);
    logic [PIN_W-1:0] stg [STAGES];

    for (genvar i = 0; i < STAGES; i++) begin : g_stage
        if (i == 0) begin : g_first
            always_ff @(posedge clk) begin
                if (rst) stg[i] <= '0;
                else     stg[i] <= pins;
            end
        end else begin : g_next
            always_ff @(posedge clk) begin
                if (rst) stg[i] <= '0;
                else     stg[i] <= stg[i-1];
            end
        end
    end

    assign synced = stg[STAGES-1];
endmodule

// File: rtl/gpio_port_bank.sv
module gpio_port_bank
    import gpio_pkg::*;
#(
    parameter int PIN_W  = 32,
    parameter int OFFS_W = 8,
    parameter int SYNC_N = 2
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              bus_req,
    input  logic              bus_we,
    input  logic [OFFS_W-1:0] bus_addr,
    input  logic [PIN_W-1:0]  bus_wdata,
    output logic [PIN_W-1:0]  bus_rdata,
    output logic              bus_ready,
    output logic              bus_err,
    input  logic [PIN_W-1:0]  pin_in,
    output logic [PIN_W-1:0]  pin_out,
    output logic [PIN_W-1:0]  pin_oe
);
    acc_t             acc;
    logic             mapped;
    logic             err_pend;
    logic [PIN_W-1:0] dout;
    logic [PIN_W-1:0] dir;
    logic [PIN_W-1:0] din;

    gpio_addr_dec #(.OFFS_W(OFFS_W)) dec_i (
        .req      (bus_req),
        .we       (bus_we),
        .addr     (bus_addr),
        .err_pend (err_pend),
        .mapped   (mapped),
        .acc      (acc)
    );

    gpio_err_fsm fsm_i (
        .clk      (clk),
        .rst      (rst),
        .req      (bus_req),
        .mapped   (mapped),
        .err_pend (err_pend),
        .ready    (bus_ready),
        .err      (bus_err)
    );

    gpio_out_regs #(.PIN_W(PIN_W)) regs_i (
        .clk   (clk),
        .rst   (rst),
        .acc   (acc),
        .wdata (bus_wdata),
        .dout  (dout),
        .dir   (dir)
    );

    gpio_in_sync #(.PIN_W(PIN_W), .STAGES(SYNC_N)) sync_i (
        .clk    (clk),
        .rst    (rst),
        .pins   (pin_in),
        .synced (din)
    );

    always_comb begin
        bus_rdata = '0;
        if (acc.fire && !acc.wr) begin
            case (acc.sel)
                SEL_DOUT: bus_rdata = dout;
                SEL_DIN:  bus_rdata = din;
                SEL_DIR:  bus_rdata = dir;
                default:  bus_rdata = '0;
            endcase
        end
    end

    assign pin_out = dout;
    assign pin_oe  = dir;
endmodule

// File: rtl/gpio_port_bank_chk.sv
module gpio_port_bank_chk #(
    parameter int PIN_W  = 32,
    parameter int OFFS_W = 8
) (
    input logic              clk,
    input logic              rst,
    input logic              bus_req,
    input logic              bus_we,
    input logic [OFFS_W-1:0] bus_addr,
    input logic [PIN_W-1:0]  bus_rdata,
    input logic              bus_ready,
    input logic              bus_err,
    input logic [PIN_W-1:0]  pin_out,
    input logic [PIN_W-1:0]  pin_oe
);
    logic dir_wr_done;
    assign dir_wr_done = bus_req && bus_we && bus_ready && !bus_err
                         && (bus_addr == OFFS_W'(8'h14));

    AST_ERR_NEEDS_READY: assert property (@(posedge clk) disable iff (rst)
        bus_err |-> bus_ready); // R8

    AST_ERR_AFTER_WAIT: assert property (@(posedge clk) disable iff (rst)
        bus_err |-> $past(bus_req && !bus_ready)); // R8

    AST_DOUT_NO_WAIT: assert property (@(posedge clk) disable iff (rst)
        (bus_req && bus_addr == '0) |-> (bus_ready && !bus_err)); // R2

    AST_SETCLR_READ_ZERO: assert property (@(posedge clk) disable iff (rst)
        (bus_req && !bus_we && bus_ready
         && (bus_addr == OFFS_W'(8'h04) || bus_addr == OFFS_W'(8'h08)))
        |-> (bus_rdata == '0)); // R3

    AST_OE_ONLY_ON_DIR_WRITE: assert property (@(posedge clk) disable iff (rst)
        !dir_wr_done |=> $stable(pin_oe)); // R5

    AST_ERR_KEEPS_STATE: assert property (@(posedge clk) disable iff (rst)
        bus_err |=> ($stable(pin_out) && $stable(pin_oe))); // R9

endmodule

bind gpio_port_bank gpio_port_bank_chk #(.PIN_W(PIN_W), .OFFS_W(OFFS_W)) chk_i (.*);

// File: tb/gpio_port_bank_tb.sv
module gpio_port_bank_tb_top;

    localparam int PIN_W  = 32;
    localparam int OFFS_W = 8;

    logic              clk = 1'b0;
    logic              rst = 1'b1;
    logic              bus_req = 1'b0;
    logic              bus_we = 1'b0;
    logic [OFFS_W-1:0] bus_addr = '0;
    logic [PIN_W-1:0]  bus_wdata = '0;
    logic [PIN_W-1:0]  bus_rdata;
    logic              bus_ready;
    logic              bus_err;
    logic [PIN_W-1:0]  pin_in = '0;
    logic [PIN_W-1:0]  pin_out;
    logic [PIN_W-1:0]  pin_oe;

    int n_chk  = 0;
    int n_fail = 0;
    bit done   = 1'b0;

    logic [31:0] m_dout = '0;
    logic [31:0] m_dir  = '0;
    logic [31:0] m_din  = '0;

    always #5 clk = ~clk;

    gpio_port_bank #(.PIN_W(PIN_W), .OFFS_W(OFFS_W)) dut_i (.*);

    function automatic bit is_mapped(input logic [7:0] off);
        return off == 8'h00 || off == 8'h04 || off == 8'h08
            || off == 8'h10 || off == 8'h14;
    endfunction

    function automatic logic [31:0] exp_read(input logic [7:0] off);
        case (off)
            8'h00:   return m_dout;
            8'h10:   return m_din;
            8'h14:   return m_dir;
            default: return 32'h0;
        endcase
    endfunction

    task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s: actual %h expected %h", req, act, exp);
        end
    endtask

    // One bus access following the handshake; returns data, wait count, error.
    task automatic access(input bit we, input logic [7:0] off, input logic [31:0] wd,
                          output logic [31:0] rd, output int waits, output bit er);
        @(negedge clk);
        bus_req = 1'b1; bus_we = we; bus_addr = off; bus_wdata = wd;
        waits = 0;
        #1;
        while (!bus_ready && waits < 4) begin
            if (bus_err) begin
                n_fail++;
                $display("FAIL R8: actual err=1 expected err=0 without ready");
            end
            waits++;
            @(negedge clk); #1;
        end
        rd = bus_rdata; er = bus_err;
        @(posedge clk); #1;
        bus_req = 1'b0; bus_we = 1'b0;
    endtask

    // Access plus model update and full comparison.
    task automatic do_op(input bit we, input logic [7:0] off, input logic [31:0] wd);
        logic [31:0] rd; int w; bit er; bit ok;
        logic [31:0] exp_rd;
        ok = is_mapped(off);
        exp_rd = exp_read(off);
        access(we, off, wd, rd, w, er);
        if (ok) begin
            check("R2 wait states", w, 0);
            check("R2 no error", {31'b0, er}, 0);
            if (!we) check(off == 8'h10 ? "R7 input read" :
                           (off == 8'h04 || off == 8'h08) ? "R3/R4 read zero" : "R2/R5 read", rd, exp_rd);
            if (we) begin
                case (off)
                    8'h00: m_dout = wd;
                    8'h04: m_dout = m_dout | wd;
                    8'h08: m_dout = m_dout & ~wd;
                    8'h14: m_dir  = wd;
                    default: ;
                endcase
            end
        end else begin
            check("R8 one wait state", w, 1);
            check("R8 error flag", {31'b0, er}, 1);
        end
        check("R6/R3/R4/R9 pin_out", pin_out, m_dout);
        check("R5/R9 pin_oe", pin_oe, m_dir);
    endtask

    task automatic set_pins(input logic [31:0] v);
        @(negedge clk);
        pin_in = v;
        repeat (3) @(negedge clk);
        m_din = v;
    endtask

    initial begin : watchdog
        repeat (100000) @(posedge clk);
        if (!done) begin
            n_fail++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("  == %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
            $finish;
        end
    end

    initial begin : stim
        logic [31:0] rd; int w; bit er;
        logic [7:0] offs [11];
        void'($urandom(32'h1357));
        offs = '{8'h00, 8'h04, 8'h08, 8'h10, 8'h14, 8'h0C, 8'h18, 8'h01, 8'h02, 8'hFC, 8'h13};

        repeat (3) @(posedge clk);
        #1 rst = 1'b0;

        // R1 reset state
        @(negedge clk);
        check("R1 pin_out reset", pin_out, 0);
        check("R1 pin_oe reset", pin_oe, 0);
        do_op(1'b0, 8'h00, '0);
        do_op(1'b0, 8'h14, '0);

        // R2 full write and read
        do_op(1'b1, 8'h00, 32'hA5A5_0F0F);
        do_op(1'b0, 8'h00, '0);
        // R3 set: only written ones change
        do_op(1'b1, 8'h04, 32'h0000_F000);
        do_op(1'b0, 8'h04, '0);
        // R4 clear
        do_op(1'b1, 8'h08, 32'h0000_0F01);
        do_op(1'b0, 8'h08, '0);
        // R5 direction, R6 value independent of direction
        do_op(1'b1, 8'h14, 32'hFFFF_0000);
        do_op(1'b0, 8'h14, '0);
        // R8/R9 unmapped writes including 0x0C and unaligned
        do_op(1'b1, 8'h0C, 32'hFFFF_FFFF);
        do_op(1'b1, 8'h01, 32'hFFFF_FFFF);
        do_op(1'b1, 8'h15, 32'h0);
        do_op(1'b0, 8'h18, '0);

        // R7 synchronizer latency
        set_pins(32'h1234_5678);
        @(negedge clk);
        pin_in = 32'hCAFE_F00D;
        access(1'b0, 8'h10, '0, rd, w, er);
        check("R7 one edge still old", rd, 32'h1234_5678);
        access(1'b0, 8'h10, '0, rd, w, er);
        check("R7 after two edges new", rd, 32'hCAFE_F00D);
        m_din = 32'hCAFE_F00D;
        // R7 write to input word ignored
        do_op(1'b1, 8'h10, 32'h0);
        do_op(1'b0, 8'h10, '0);

        // random mix
        for (int i = 0; i < 400; i++) begin
            logic [7:0] off;
            off = offs[$urandom_range(0, 10)];
            if ($urandom_range(0, 15) == 0) set_pins($urandom);
            do_op($urandom_range(0, 1) == 1, off, $urandom);
        end

        done = 1'b1;
        $display("  == %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
        $finish;
    end

endmodule